// File: doc/BRIEF.md
# Programmable System Clock Selector and Divider

This block turns one of three source tick inputs into a system clock-enable strobe. The sources are a frequency-multiplier (PLL) tick, a main-oscillator tick and a real-time-clock oscillator tick. All of them are single-cycle pulses in one reference clock domain. The block picks one source and passes its ticks through a divider. It then emits a single-cycle enable pulse once every N accepted ticks. N comes from a 4-bit code that maps to a nonlinear set of ratios.

An 8-bit speed register holds all the settings:

| Bits | Field |
|------|-------|
| 7 | PLL power-down |
| 6 | oscillator power-down |
| 5:4 | source select |
| 3:0 | divisor code |

Only a dedicated load strobe with its own data input can change the register. The ordinary bus sees it as a read-only value. A status output reports when no enable pulses can be produced. This happens when the select is off, the divisor is off, or the chosen source is powered down.

Top module: `sysclk_divsel`

## Requirements
- R1: After reset the speed register reads 0x10 (oscillator source, divide-by-1, both sources powered), `sys_en` is low and `clk_stopped` is low.
- R2: A cycle with `spd_load` high stores `spd_wdata`, and `spd_rdata` shows it from the next cycle on. Without `spd_load` the register keeps its value.
- R3: Select field bits 5:4 choose the source: 00 = `pll_tick`, 01 = `osc_tick`, 10 = `rtc_tick`. Ticks on the two lines that are not selected have no effect.
- R4: Divisor code bits 3:0 map values 0 to 14 to ratios 1, 2, 3, 4, 5, 6, 8, 10, 12, 16, 24, 32, 48, 64, 128. One `sys_en` pulse follows every N-th accepted tick.
- R5: With code 0 (divide-by-1), every accepted tick produces a `sys_en` pulse, including ticks on back-to-back cycles.
- R6: Select value 11 stops the output: no `sys_en` pulses occur.
- R7: Divisor code 1111 stops the output whatever source is selected.
- R8: Bit 7 = 1 powers down the PLL source and bit 6 = 1 powers down the oscillator source. A powered-down selected source yields no pulses. Powering down a source that is not selected changes nothing.
- R9: A load clears the divide counter and discards any tick arriving in the load cycle. `sys_en` is low in the cycle after a load, and the first pulse follows the N-th accepted tick after the load.
- R10: `clk_stopped` is high exactly when select is 11, or the code is 1111, or the selected source is powered down. While it is high, no tick is accepted.
- R11: `sys_en` is registered. It rises in the cycle right after the clock edge that samples the N-th accepted tick, and it lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pll_tick | input | 1 | Single-cycle tick from the multiplier source |
| osc_tick | input | 1 | Single-cycle tick from the main oscillator |
| rtc_tick | input | 1 | Single-cycle tick from the real-time-clock oscillator |
| spd_load | input | 1 | Dedicated speed-register load strobe |
| spd_wdata | input | 8 | Value stored on a load |
| spd_rdata | output | 8 | Read-only view of the speed register |
| sys_en | output | 1 | System clock-enable pulse |
| clk_stopped | output | 1 | High while no enable pulse can be produced |

## Verification
The assertions take for granted that the source ticks are synchronous to `clk` and that each is a clean one-cycle level sampled at the rising edge. They also assume `spd_load` is never held through reset, so the register history they compare against begins at the first cycle out of reset. The stimulus drives every input on the falling edge. The three tick lines run on fixed, distinct periodic patterns, so a tick on a line that is not selected often lands in a cycle where the selected line is quiet. Each load also raises all three ticks together, which exercises the rule that ticks in the load cycle are discarded.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;

    localparam int SPD_W = 8;

    localparam logic [1:0] SRC_PLL = 2'b00;
    localparam logic [1:0] SRC_OSC = 2'b01;
    localparam logic [1:0] SRC_RTC = 2'b10;
    localparam logic [1:0] SRC_OFF = 2'b11;

    localparam logic [3:0] DCODE_OFF = 4'hF;

    typedef struct packed {
        logic       pll_off;
        logic       osc_off;
        logic [1:0] src;
        logic [3:0] dcode;
    } spd_t;

endpackage

// File: rtl/sysclk_div_lut.sv
module sysclk_div_lut #(
    parameter int CNT_W = 8
) (
    input  logic [3:0]       dcode,
    output logic [CNT_W-1:0] div_m1
);
    always_comb begin
        case (dcode)
            4'd0:    div_m1 = CNT_W'(0);
            4'd1:    div_m1 = CNT_W'(1);
            4'd2:    div_m1 = CNT_W'(2);
            4'd3:    div_m1 = CNT_W'(3);
            4'd4:    div_m1 = CNT_W'(4);
            4'd5:    div_m1 = CNT_W'(5);
            4'd6:    div_m1 = CNT_W'(7);
            4'd7:    div_m1 = CNT_W'(9);
            4'd8:    div_m1 = CNT_W'(11);
            4'd9:    div_m1 = CNT_W'(15);
            4'd10:   div_m1 = CNT_W'(23);
            4'd11:   div_m1 = CNT_W'(31);
            4'd12:   div_m1 = CNT_W'(47);
            4'd13:   div_m1 = CNT_W'(63);
            4'd14:   div_m1 = CNT_W'(127);
            default: div_m1 = CNT_W'(0);
        endcase
    end
endmodule

// File: rtl/sysclk_src_gate.sv
module sysclk_src_gate
    import sysclk_pkg::*;
(
    input  spd_t cfg,
    input  logic pll_tick,
    input  logic osc_tick,
    input  logic rtc_tick,
    output logic src_tick,
    output logic stopped
);
    localparam int NSRC = 4;

    logic [NSRC-1:0] tick_vec;
    logic [NSRC-1:0] pwr_ok;

    assign tick_vec = {1'b0, rtc_tick, osc_tick, pll_tick};
    assign pwr_ok   = {1'b0, 1'b1, ~cfg.osc_off, ~cfg.pll_off};

    always_comb begin
        stopped  = (cfg.dcode == DCODE_OFF) || !pwr_ok[cfg.src];
        src_tick = !stopped && tick_vec[cfg.src];
    end
endmodule

// File: rtl/sysclk_tick_div.sv
module sysclk_tick_div #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] div_m1,
    output logic             pulse
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (clear) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (st_q.cnt >= div_m1) begin
                st_d.cnt   = '0;
                st_d.pulse = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse = st_q.pulse;
endmodule

// File: rtl/sysclk_divsel.sv
module sysclk_divsel
    import sysclk_pkg::*;
#(
    parameter int               CNT_W   = 8,
    parameter logic [SPD_W-1:0] RST_VAL = 8'h10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pll_tick,
    input  logic             osc_tick,
    input  logic             rtc_tick,
    input  logic             spd_load,
    input  logic [SPD_W-1:0] spd_wdata,
    output logic [SPD_W-1:0] spd_rdata,
    output logic             sys_en,
    output logic             clk_stopped
);
    spd_t             spd_d, spd_q;
    logic             src_tick;
    logic [CNT_W-1:0] div_m1;

    always_comb begin
        spd_d = spd_q;
        if (spd_load) spd_d = spd_t'(spd_wdata);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) spd_q <= spd_t'(RST_VAL);
        else        spd_q <= spd_d;
    end

    sysclk_src_gate gate_i (
        .cfg      (spd_q),
        .pll_tick (pll_tick),
        .osc_tick (osc_tick),
        .rtc_tick (rtc_tick),
        .src_tick (src_tick),
        .stopped  (clk_stopped)
    );

    sysclk_div_lut #(.CNT_W(CNT_W)) lut_i (
        .dcode  (spd_q.dcode),
        .div_m1 (div_m1)
    );

    sysclk_tick_div #(.CNT_W(CNT_W)) div_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (spd_load),
        .tick   (src_tick),
        .div_m1 (div_m1),
        .pulse  (sys_en)
    );

    assign spd_rdata = spd_q;
endmodule

// File: rtl/sysclk_divsel_chk.sv
module sysclk_divsel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       spd_load,
    input logic [7:0] spd_wdata,
    input logic [7:0] spd_rdata,
    input logic       sys_en,
    input logic       clk_stopped,
    input logic       src_tick
);
    // R11
    pulse_follows_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_en |-> $past(src_tick));

    // R9
    load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spd_load |=> !sys_en);

    // R2
    load_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spd_load |=> (spd_rdata == $past(spd_wdata)));

    // R2
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !spd_load |=> $stable(spd_rdata));

    // R10
    stopped_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_stopped |-> !src_tick);

    // R6
    sel_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spd_rdata[5:4] == 2'b11) |-> clk_stopped);

    // R7
    code_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spd_rdata[3:0] == 4'hF) |-> clk_stopped);
endmodule

bind sysclk_divsel sysclk_divsel_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .spd_load    (spd_load),
    .spd_wdata   (spd_wdata),
    .spd_rdata   (spd_rdata),
    .sys_en      (sys_en),
    .clk_stopped (clk_stopped),
    .src_tick    (src_tick)
);

// File: tb/sysclk_divsel_tb_top.sv
`timescale 1ns/1ps
module sysclk_divsel_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pll_tick = 1'b0, osc_tick = 1'b0, rtc_tick = 1'b0;
    logic       spd_load = 1'b0;
    logic [7:0] spd_wdata = 8'h00;
    logic [7:0] spd_rdata;
    logic       sys_en, clk_stopped;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sysclk_divsel dut_i (
        .clk(clk), .rst_n(rst_n),
        .pll_tick(pll_tick), .osc_tick(osc_tick), .rtc_tick(rtc_tick),
        .spd_load(spd_load), .spd_wdata(spd_wdata), .spd_rdata(spd_rdata),
        .sys_en(sys_en), .clk_stopped(clk_stopped)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int ratio(input int code);
        case (code)
            6: return 8;   7: return 10;  8: return 12;  9: return 16;
            10: return 24; 11: return 32; 12: return 48; 13: return 64;
            14: return 128;
            default: return code + 1;
        endcase
    endfunction

    function automatic bit exp_stop(input int src, input int code, input bit poff, input bit ooff);
        return (src == 3) || (code == 15) || (src == 0 && poff) || (src == 1 && ooff);
    endfunction

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rdata", spd_rdata, 8'h10);
        check("R1 sys_en", sys_en, 0);
        check("R1 stopped", clk_stopped, 0);

        for (int src = 0; src < 4; src++) begin
            for (int pw = 0; pw < 4; pw++) begin
                for (int code = 0; code < 16; code++) begin
                    automatic bit   poff = pw[1];
                    automatic bit   ooff = pw[0];
                    automatic logic [7:0] val = {poff, ooff, 2'(src), 4'(code)};
                    automatic bit   stop = exp_stop(src, code, poff, ooff);
                    automatic int   n = (code == 15) ? 1 : ratio(code);
                    automatic int   cyc = stop ? 24 : n * 2 * (src + 2) + 6;
                    automatic int   cnt = 0;
                    automatic bit   exp_en;
                    automatic string tag;
                    if (src == 3) tag = "R6";
                    else if (code == 15) tag = "R7";
                    else if (stop) tag = "R8";
                    else if (code == 0) tag = "R5";
                    else tag = "R4";
                    // load cycle with all ticks high: R9 discards them
                    spd_load = 1'b1; spd_wdata = val;
                    pll_tick = 1'b1; osc_tick = 1'b1; rtc_tick = 1'b1;
                    @(negedge clk);
                    spd_load = 1'b0; spd_wdata = ~val;
                    pll_tick = 1'b0; osc_tick = 1'b0; rtc_tick = 1'b0;
                    check("R2 readback", spd_rdata, val);
                    check("R10 stopped", clk_stopped, stop);
                    check("R9 quiet after load", sys_en, 0);
                    for (int i = 0; i < cyc; i++) begin
                        automatic bit tp = (i % 2 == 0);
                        automatic bit to = (i % 3 == 1);
                        automatic bit tr = (i % 4 == 2);
                        automatic bit sel;
                        if (src == 0 && code == 0 && i < 6) tp = 1'b1; // R5 back-to-back
                        pll_tick = tp; osc_tick = to; rtc_tick = tr;
                        sel = (src == 0) ? tp : (src == 1) ? to : (src == 2) ? tr : 1'b0;
                        exp_en = 1'b0;
                        if (sel && !stop) begin
                            cnt++;
                            exp_en = (cnt % n == 0);
                        end
                        @(negedge clk);
                        // R11 pulse appears the cycle after the N-th accepted tick; R3 source map
                        check({tag, " R3 R11 sys_en"}, sys_en, exp_en);
                    end
                    pll_tick = 1'b0; osc_tick = 1'b0; rtc_tick = 1'b0;
                    @(negedge clk);
                    check("R11 single pulse", sys_en, 0);
                    check("R2 hold", spd_rdata, val);
                end
            end
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule